// File: doc/BRIEF.md
# Fetch-Side Branch History Predictor

This block sits next to an instruction fetch stage. In the same cycle that the fetch stage presents an address, it looks that address up in a small direct-mapped table of recently seen branches. When the lookup hits, the entry's one-bit taken/not-taken switch chooses the next fetch address. If the switch says taken, the next address is the stored target. Otherwise it is the fall-through address. When the lookup misses, fetch simply continues sequentially.

When a branch resolves in the execute stage, the stage returns four items:
- the branch address;
- its real direction;
- its real target;
- the next address that fetch actually used after it.

The block works out the correct successor and raises a flush when that successor differs from the address fetch used. The cause may be a wrong direction or a wrong target. During a flush the next fetch address is forced to the correct successor, and the surrounding pipeline discards the instructions fetched down the wrong path. In the same step the table learns from the outcome.

Top module: `bht_predictor`

## Requirements
- R1: After reset every lookup misses: `pred_hit` is 0 and `next_pc` is `fetch_pc + 4`.
- R2: Addresses map to one of 16 entries by `pc[5:2]`, and the tag is `pc[31:6]`. A lookup hits when the entry is valid and the tags are equal. A hit whose switch is set gives `pred_taken` = 1 and `next_pc` = the stored target.
- R3: A hit whose switch is clear gives `pred_taken` = 0 and `next_pc` = `fetch_pc + 4`.
- R4: A valid entry at the same index with a different tag is a miss, and fetch is sequential.
- R5: A resolved taken branch that has no entry allocates one, holding its tag, its target and a set switch. From the next cycle onward, lookups of that address predict taken to that target.
- R6: A resolved not-taken branch that has no entry leaves the table unchanged, so a later lookup of it still misses.
- R7: A resolved branch that hits its entry sets the switch to the real direction. When the direction is taken, the stored target is also replaced by the real target.
- R8: Allocation overwrites whatever entry occupied the index, so the old address misses afterwards.
- R9: `flush` is 1 exactly when `res_valid` is 1 and `res_used_next` differs from the correct successor. The correct successor is `res_target` for a taken branch and `res_pc + 4` otherwise. A wrong direction is one of the cases that raises it.
- R10: A taken branch whose direction was guessed right but whose target was guessed wrong also raises `flush`.
- R11: While `flush` is 1, `next_pc` equals `redirect_pc`, the correct successor, whatever the lookup gives.
- R12: When an update and a lookup address the same entry in one cycle, the lookup returns the contents as they were before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | Lookup found a valid entry with a matching tag |
| pred_taken | output | 1 | Lookup hit and the entry predicts taken |
| next_pc | output | 32 | Address to fetch next |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Real direction of the branch |
| res_target | input | 32 | Real target of the branch |
| res_used_next | input | 32 | Next address fetch used after this branch |
| flush | output | 1 | Misprediction: discard wrong-path instructions |
| redirect_pc | output | 32 | Correct successor of the resolving branch |

## Verification
The bench works through several corner cases and names the fault each one would expose:
- A branch that aliases an occupied index: a design that ignores the tag would return another branch's target.
- A not-taken branch with no entry: a design that allocates anyway would turn a later sequential fetch into a hit.
- A right direction with a stale target: a design that compares only the direction would miss the flush and fetch down the wrong path.
- An update and a lookup of the same entry in one cycle: the lookup must see the entry as it was, so a design that forwards the new value shows a changed `pred_taken` one cycle early.
- A flush cycle in which the lookup also hits: a design that lets the lookup win would send fetch to the predicted address instead of the correct one.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_STEP    = 4;

  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_REFRESH = 2'd1,
    UPD_ALLOC   = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/bhp_table.sv
module bhp_table #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 26,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rda_idx,
  output logic              rda_valid,
  output logic [TAG_W-1:0]  rda_tag,
  output logic              rda_taken,
  output logic [ADDR_W-1:0] rda_target,
  input  logic [IDX_W-1:0]  rdb_idx,
  output logic              rdb_valid,
  output logic [TAG_W-1:0]  rdb_tag,
  output logic [ADDR_W-1:0] rdb_target,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_taken,
  input  logic [ADDR_W-1:0] wr_target
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  target_q [ENTRIES];
  logic [ENTRIES-1:0] taken_q;
  logic [ENTRIES-1:0] slot_we;

  always_comb begin
    slot_we = '0;
    if (wr_en) slot_we[wr_idx] = 1'b1;
    valid_d = valid_q | slot_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (slot_we[e]) begin
        tag_q[e]    <= wr_tag;
        target_q[e] <= wr_target;
        taken_q[e]  <= wr_taken;
      end
    end
  end

  assign rda_valid  = valid_q[rda_idx];
  assign rda_tag    = tag_q[rda_idx];
  assign rda_taken  = taken_q[rda_idx];
  assign rda_target = target_q[rda_idx];
  assign rdb_valid  = valid_q[rdb_idx];
  assign rdb_tag    = tag_q[rdb_idx];
  assign rdb_target = target_q[rdb_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)); // R5
  AST_IDLE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> valid_q == $past(valid_q)); // R6
endmodule

// File: rtl/bhp_resolve.sv
module bhp_resolve #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TAG_W   = 26,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned OFS_W   = 2,
  parameter int unsigned STEP    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic [ADDR_W-1:0] res_used_next,
  output logic [IDX_W-1:0]  look_idx,
  input  logic              look_valid,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic [ADDR_W-1:0] look_target,
  output logic              wr_en,
  output logic [TAG_W-1:0]  wr_tag,
  output logic              wr_taken,
  output logic [ADDR_W-1:0] wr_target,
  output logic              mispredict,
  output logic [ADDR_W-1:0] correct_next
);
  import bhp_pkg::*;

  logic       res_hit;
  logic [ADDR_W-1:0] fall_next;
  upd_kind_e  kind;

  assign look_idx  = res_pc[OFS_W +: IDX_W];
  assign wr_tag    = res_pc[ADDR_W-1 -: TAG_W];
  assign res_hit   = look_valid && (look_tag == wr_tag);
  assign fall_next = res_pc + ADDR_W'(STEP);

  always_comb begin
    kind = UPD_NONE;
    if (res_valid) begin
      if (res_hit)        kind = UPD_REFRESH;
      else if (res_taken) kind = UPD_ALLOC;
    end
  end

  assign wr_en        = (kind != UPD_NONE);
  assign wr_taken     = res_taken;
  assign wr_target    = res_taken ? res_target : look_target;
  assign correct_next = res_taken ? res_target : fall_next;
  assign mispredict   = res_valid && (res_used_next != correct_next);

  AST_DIRECTION_FLIP_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken && res_used_next == fall_next && res_target != fall_next)
      |-> mispredict); // R9
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor #(
  parameter int unsigned ADDR_W  = bhp_pkg::DEF_ADDR_W,
  parameter int unsigned ENTRIES = bhp_pkg::DEF_ENTRIES,
  parameter int unsigned STEP    = bhp_pkg::DEF_STEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] next_pc,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic [ADDR_W-1:0] res_used_next,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned OFS_W = $clog2(STEP);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFS_W;

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0]  f_idx, r_idx;
  logic              f_valid, f_taken, r_valid;
  logic [TAG_W-1:0]  f_tag, r_tag, w_tag;
  logic [ADDR_W-1:0] f_target, r_target, w_target;
  logic              w_en, w_taken;
  logic [ADDR_W-1:0] seq_next, guess_next;
  logic              unused_low;

  assign f_idx      = fetch_pc[OFS_W +: IDX_W];
  assign unused_low = ^{fetch_pc[OFS_W-1:0], res_pc[OFS_W-1:0]};

  bhp_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_sync_q),
    .rda_idx(f_idx), .rda_valid(f_valid), .rda_tag(f_tag),
    .rda_taken(f_taken), .rda_target(f_target),
    .rdb_idx(r_idx), .rdb_valid(r_valid), .rdb_tag(r_tag), .rdb_target(r_target),
    .wr_en(w_en), .wr_idx(r_idx), .wr_tag(w_tag),
    .wr_taken(w_taken), .wr_target(w_target)
  );

  bhp_resolve #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W),
                .OFS_W(OFS_W), .STEP(STEP)) u_resolve (
    .clk(clk), .rst_n(rst_sync_q),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_used_next(res_used_next),
    .look_idx(r_idx), .look_valid(r_valid), .look_tag(r_tag),
    .look_target(r_target),
    .wr_en(w_en), .wr_tag(w_tag), .wr_taken(w_taken), .wr_target(w_target),
    .mispredict(flush), .correct_next(redirect_pc)
  );

  assign pred_hit   = f_valid && (f_tag == fetch_pc[ADDR_W-1 -: TAG_W]);
  assign pred_taken = pred_hit && f_taken;
  assign seq_next   = fetch_pc + ADDR_W'(STEP);
  assign guess_next = pred_taken ? f_target : seq_next;
  assign next_pc    = flush ? redirect_pc : guess_next;

  AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    flush |-> next_pc == redirect_pc); // R11
  AST_MISS_FALLS_THROUGH: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!flush && !pred_hit) |-> next_pc == fetch_pc + ADDR_W'(STEP)); // R4
  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    pred_taken |-> pred_hit); // R2
endmodule

// File: tb/bht_predictor_test.sv
module bht_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc, next_pc, res_pc, res_target, res_used_next, redirect_pc;
  logic        pred_hit, pred_taken, res_valid, res_taken, flush;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] nxt;
    logic        hit;
    logic        tkn;
    logic        fl;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  bht_predictor uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .next_pc(next_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_used_next(res_used_next),
    .flush(flush), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, "next_pc", next_pc, e.nxt);
      chk(e.req, "pred_hit", {31'd0, pred_hit}, {31'd0, e.hit});
      chk(e.req, "pred_taken", {31'd0, pred_taken}, {31'd0, e.tkn});
      chk(e.req, "flush", {31'd0, flush}, {31'd0, e.fl});
    end
  end

  // driver: one cycle of stimulus plus its expected outputs
  task automatic step(input logic [31:0] fpc, input logic rv, input logic [31:0] rpc,
                      input logic rt, input logic [31:0] rtgt, input logic [31:0] rused,
                      input logic [31:0] enxt, input logic ehit, input logic etkn,
                      input logic efl, input string req);
    exp_t e;
    @(posedge clk); #1;
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt;
    res_target = rtgt; res_used_next = rused;
    e.nxt = enxt; e.hit = ehit; e.tkn = etkn; e.fl = efl; e.req = req;
    sb.push_back(e);
  endtask

  localparam logic [31:0] A = 32'h100;  // index 0
  localparam logic [31:0] B = 32'h140;  // index 0, other tag
  localparam logic [31:0] C = 32'h208;  // index 2

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_pc = 0; res_valid = 0; res_pc = 0; res_taken = 0;
    res_target = 0; res_used_next = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 empty after reset
    step(A, 0, 0, 0, 0, 0, 32'h104, 0, 0, 0, "R1");
    // R9 taken branch predicted sequential: flush, R11 redirect, R5 allocate
    step(32'h108, 1, A, 1, 32'h400, 32'h104, 32'h400, 0, 0, 1, "R9");
    // R5 / R2 allocated entry predicts taken
    step(A, 0, 0, 0, 0, 0, 32'h400, 1, 1, 0, "R5");
    // R4 same index, different tag
    step(B, 0, 0, 0, 0, 0, 32'h144, 0, 0, 0, "R4");
    // R9 correct not-taken guess, no flush; lookup of other tag misses
    step(32'h300, 1, C, 0, 32'h900, 32'h20C, 32'h304, 0, 0, 0, "R9");
    // R6 not-taken miss did not allocate
    step(C, 0, 0, 0, 0, 0, 32'h20C, 0, 0, 0, "R6");
    // R9 wrong direction (predicted taken, went not-taken); R11
    step(32'h180, 1, A, 0, 32'h0, 32'h400, 32'h104, 0, 0, 1, "R11");
    // R7 / R3 switch cleared on hit
    step(A, 0, 0, 0, 0, 0, 32'h104, 1, 0, 0, "R3");
    // R12 update and lookup same entry: old switch seen; redirect wins
    step(A, 1, A, 1, 32'h500, 32'h104, 32'h500, 1, 0, 1, "R12");
    // R7 switch and target refreshed
    step(A, 0, 0, 0, 0, 0, 32'h500, 1, 1, 0, "R7");
    // R10 right direction, wrong target
    step(32'h0, 1, A, 1, 32'h600, 32'h500, 32'h600, 0, 0, 1, "R10");
    // R9 right direction and target: no flush
    step(32'h0, 1, A, 1, 32'h600, 32'h600, 32'h4, 0, 0, 0, "R9");
    // R11 flush overrides a hitting lookup
    step(A, 1, C, 1, 32'h800, 32'h20C, 32'h800, 1, 1, 1, "R11");
    // R8 allocation replaces occupant of index 0
    step(32'h0, 1, B, 1, 32'h700, 32'h144, 32'h700, 0, 0, 1, "R8");
    step(A, 0, 0, 0, 0, 0, 32'h104, 0, 0, 0, "R8");
    step(B, 0, 0, 0, 0, 0, 32'h700, 1, 1, 0, "R8");
    step(C, 0, 0, 0, 0, 0, 32'h800, 1, 1, 0, "R5");
    @(posedge clk); #1;
    res_valid = 0;
    @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule